// File: doc/BRIEF.md
# Daisy-Chained Depth-Expansion Queue

This block builds one deep first-in/first-out queue out of several identical storage slices connected in a ring. Each slice owns a fixed number of word locations. Ownership of the write side and of the read side are two separate tokens that travel around the ring. After reset the slice marked as leader holds both tokens and every other slice holds none. A slice stores an incoming word only while it owns the write token and has room. It delivers a word only while it owns the read token and holds data. When a slice fills its highest location, it raises a one-cycle pass pulse toward its successor and gives up the write token. The successor takes the token on the next clock edge. The read token moves the same way when a slice's highest location is drained. Because words fill the slices in ring order and are drained in the same order, the ring behaves as a single queue whose capacity is the sum of the slices.

Words enter through a valid/ready stream and leave through a second valid/ready stream. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` never depends on `in_valid`. A word is removed on a rising edge where `out_valid` and `out_ready` are both high. `out_valid` never depends on `out_ready`. A producer must hold its word stable until it is taken. Only the slice owning the read token drives the shared output word. The combined status flags are built from the per-slice flags. The near-full and near-empty composites are coarse by design.

Top module: `chain_fifo`

## Requirements
- R1: On reset release slice 0 owns both tokens. `in_ready`=1, `out_valid`=0, `rd_empty`=1, `wr_full`=0, `near_empty`=1 and `near_full`=0.
- R2: Words leave in the order they were accepted, across every slice boundary and every wrap of the ring.
- R3: Each slice takes exactly DEPTH words before handing on the write token. In the cycle after the word that fills a slice's highest location is accepted, `in_ready` is 0. The following slice accepts from the cycle after that.
- R4: In the cycle after the word from a slice's highest location is removed, `out_valid` is 0, even if the next slice holds data. The next slice delivers from the cycle after that.
- R5: At no time does more than one slice own the write token, and at no time does more than one slice own the read token.
- R6: When the write-token slice is full, `wr_full`=1 and `in_ready`=0. Words offered then are not stored and never appear at the output.
- R7: When the read-token slice is empty, `rd_empty`=1 and `out_valid`=0. `out_ready` then removes nothing.
- R8: `near_full` is 1 exactly when at least one slice holds DEPTH-AFULL_GAP or more words.
- R9: `near_empty` is 1 exactly when every slice holds AEMPTY_GAP or fewer words.
- R10: A pass pulse lasts one cycle. During that cycle no slice owns the token being passed, and the successor owns it in the next cycle.
- R11: `out_data` is all zeros whenever `out_valid` is 0.
- R12: A word may be accepted and another removed on the same edge. Each side's handoff then proceeds independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both streams |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Write-token slice can store a word |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Read-token slice holds a word |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DATA_W | Oldest word, zero when not valid |
| wr_full | output | 1 | Write-token slice is full |
| rd_empty | output | 1 | Read-token slice is empty |
| near_full | output | 1 | Some slice at or above its high mark |
| near_empty | output | 1 | All slices at or below their low mark |

## Verification
The write handoff and the read handoff can fall in the same cycle, and a push and a pop can land on one slice on the same edge while either token is moving. Long runs with both `in_valid` and `out_ready` held high, followed by random bursts with shifting probabilities, drive both tokens around the ring several times, often one location apart. Each cycle the bench compares the stall cycles of both streams, the per-slice fill levels behind the composite flags, and the word order against a token-level model and a separate ordered scoreboard.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;

  typedef struct packed {
    logic full;
    logic empty;
    logic near_full;
    logic near_empty;
  } slice_flags_t;

endpackage

// File: rtl/chain_fifo_ring.sv
// Location pointer plus token ownership for one side (write or read) of a slice.
module chain_fifo_ring #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lead_n,
  input  logic             step,
  input  logic             pass_in,
  output logic             own,
  output logic             pass_out,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic at_last;
  assign at_last = (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own      <= ~lead_n;
      pass_out <= 1'b0;
      ptr      <= '0;
    end else begin
      pass_out <= step & at_last;
      if (step) begin
        ptr <= at_last ? '0 : ptr + 1'b1;
      end
      if (pass_in) begin
        own <= 1'b1;
      end else if (step && at_last) begin
        own <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/chain_fifo_store.sv
module chain_fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/chain_fifo_slice.sv
module chain_fifo_slice
  import chain_fifo_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 4,
  parameter int AFULL_GAP  = 1,
  parameter int AEMPTY_GAP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_pass_in,
  input  logic              rd_pass_in,
  output logic              wr_pass_out,
  output logic              rd_pass_out,
  output logic              wr_own,
  output logic              rd_own,
  output logic [DATA_W-1:0] head,
  output slice_flags_t      flags
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_HI   = CNT_W'(DEPTH - AFULL_GAP);
  localparam logic [CNT_W-1:0] CNT_LO   = CNT_W'(AEMPTY_GAP);

  logic [CNT_W-1:0]  cnt;
  logic [PTR_W-1:0]  wptr;
  logic [PTR_W-1:0]  rptr;
  logic [DATA_W-1:0] rd_word;
  logic              wr_go;
  logic              rd_go;

  assign wr_go = push & wr_own & (cnt != CNT_FULL);
  assign rd_go = pop  & rd_own & (cnt != '0);

  chain_fifo_ring #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wr_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .lead_n   (lead_n),
    .step     (wr_go),
    .pass_in  (wr_pass_in),
    .own      (wr_own),
    .pass_out (wr_pass_out),
    .ptr      (wptr)
  );

  chain_fifo_ring #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rd_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .lead_n   (lead_n),
    .step     (rd_go),
    .pass_in  (rd_pass_in),
    .own      (rd_own),
    .pass_out (rd_pass_out),
    .ptr      (rptr)
  );

  chain_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_go),
    .wr_addr (wptr),
    .wr_data (wr_data),
    .rd_addr (rptr),
    .rd_data (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_go && !rd_go) begin
      cnt <= cnt + 1'b1;
    end else if (rd_go && !wr_go) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign flags.full       = (cnt == CNT_FULL);
  assign flags.empty      = (cnt == '0);
  assign flags.near_full  = (cnt >= CNT_HI);
  assign flags.near_empty = (cnt <= CNT_LO);

  // only the read-token owner puts a word on the shared bus
  assign head = (rd_own && cnt != '0) ? rd_word : '0;

endmodule

// File: rtl/chain_fifo.sv
module chain_fifo
  import chain_fifo_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 4,
  parameter int NUM_DEV    = 3,
  parameter int AFULL_GAP  = 1,
  parameter int AEMPTY_GAP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              wr_full,
  output logic              rd_empty,
  output logic              near_full,
  output logic              near_empty
);

  logic [NUM_DEV-1:0] wtok_v;
  logic [NUM_DEV-1:0] rtok_v;
  logic [NUM_DEV-1:0] wexo_v;
  logic [NUM_DEV-1:0] rexo_v;
  logic [NUM_DEV-1:0] full_v;
  logic [NUM_DEV-1:0] empty_v;
  logic [NUM_DEV-1:0] nf_v;
  logic [NUM_DEV-1:0] ne_v;
  logic [DATA_W-1:0]  head_a [NUM_DEV];

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_slice
    localparam int PREV = (i + NUM_DEV - 1) % NUM_DEV;
    slice_flags_t fl;

    chain_fifo_slice #(
      .DATA_W     (DATA_W),
      .DEPTH      (DEPTH),
      .AFULL_GAP  (AFULL_GAP),
      .AEMPTY_GAP (AEMPTY_GAP)
    ) u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .lead_n      ((i == 0) ? 1'b0 : 1'b1),
      .push        (in_valid),
      .pop         (out_ready),
      .wr_data     (in_data),
      .wr_pass_in  (wexo_v[PREV]),
      .rd_pass_in  (rexo_v[PREV]),
      .wr_pass_out (wexo_v[i]),
      .rd_pass_out (rexo_v[i]),
      .wr_own      (wtok_v[i]),
      .rd_own      (rtok_v[i]),
      .head        (head_a[i]),
      .flags       (fl)
    );

    assign full_v[i]  = fl.full;
    assign empty_v[i] = fl.empty;
    assign nf_v[i]    = fl.near_full;
    assign ne_v[i]    = fl.near_empty;
  end

  always_comb begin
    out_data = '0;
    for (int k = 0; k < NUM_DEV; k++) begin
      out_data = out_data | head_a[k];
    end
  end

  assign wr_full    = |(wtok_v & full_v);
  assign in_ready   = |(wtok_v & ~full_v);
  assign out_valid  = |(rtok_v & ~empty_v);
  assign rd_empty   = ~out_valid;
  assign near_full  = |nf_v;
  assign near_empty = &ne_v;

endmodule

// File: rtl/chain_fifo_chk.sv
module chain_fifo_chk #(
  parameter int NUM_DEV = 3,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DEV-1:0] wtok_v,
  input logic [NUM_DEV-1:0] rtok_v,
  input logic [NUM_DEV-1:0] wexo_v,
  input logic [NUM_DEV-1:0] rexo_v,
  input logic               in_ready,
  input logic               out_valid,
  input logic [DATA_W-1:0]  out_data,
  input logic               wr_full
);

  a_r5_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wtok_v));

  a_r5_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rtok_v));

  a_r3_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (|wexo_v) |-> !in_ready);

  a_r4_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (|rexo_v) |-> !out_valid);

  a_r10_wr_pass_short: assert property (@(posedge clk) disable iff (!rst_n)
    (wexo_v & $past(wexo_v)) == '0);

  a_r10_rd_pass_short: assert property (@(posedge clk) disable iff (!rst_n)
    (rexo_v & $past(rexo_v)) == '0);

  a_r10_wr_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (|wexo_v) |-> (wtok_v == '0));

  a_r10_wr_arrives: assert property (@(posedge clk) disable iff (!rst_n)
    (|wexo_v) |=> (|wtok_v));

  a_r10_rd_arrives: assert property (@(posedge clk) disable iff (!rst_n)
    (|rexo_v) |=> (|rtok_v));

  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |-> !in_ready);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

endmodule

bind chain_fifo chain_fifo_chk #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wtok_v    (wtok_v),
  .rtok_v    (rtok_v),
  .wexo_v    (wexo_v),
  .rexo_v    (rexo_v),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .wr_full   (wr_full)
);

// File: tb/test_chain_fifo.sv
module test_chain_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int D   = 4;
  localparam int N   = 3;
  localparam int AFG = 1;
  localparam int AEG = 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, out_valid, wr_full, rd_empty, near_full, near_empty;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // token-level model
  int           m_cnt [N];
  int           m_wp  [N];
  int           m_rp  [N];
  bit           m_wt  [N];
  bit           m_rt  [N];
  bit           m_wx  [N];
  bit           m_rx  [N];
  logic [W-1:0] m_mem [N][D];
  logic [W-1:0] sb [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_fifo #(.DATA_W(W), .DEPTH(D), .NUM_DEV(N), .AFULL_GAP(AFG), .AEMPTY_GAP(AEG)) i_chain_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .wr_full    (wr_full),
    .rd_empty   (rd_empty),
    .near_full  (near_full),
    .near_empty (near_empty)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int k = 0; k < N; k++) begin
      m_cnt[k] = 0; m_wp[k] = 0; m_rp[k] = 0;
      m_wt[k] = (k == 0); m_rt[k] = (k == 0);
      m_wx[k] = 0; m_rx[k] = 0;
    end
  endfunction

  function automatic bit exp_ready();
    bit r = 0;
    for (int k = 0; k < N; k++) if (m_wt[k] && m_cnt[k] != D) r = 1;
    return r;
  endfunction

  function automatic bit exp_full();
    bit r = 0;
    for (int k = 0; k < N; k++) if (m_wt[k] && m_cnt[k] == D) r = 1;
    return r;
  endfunction

  function automatic bit exp_valid();
    bit r = 0;
    for (int k = 0; k < N; k++) if (m_rt[k] && m_cnt[k] != 0) r = 1;
    return r;
  endfunction

  function automatic int exp_data();
    for (int k = 0; k < N; k++) if (m_rt[k] && m_cnt[k] != 0) return int'(m_mem[k][m_rp[k]]);
    return 0;
  endfunction

  function automatic bit exp_nf();
    bit r = 0;
    for (int k = 0; k < N; k++) if (m_cnt[k] >= D - AFG) r = 1;
    return r;
  endfunction

  function automatic bit exp_ne();
    bit r = 1;
    for (int k = 0; k < N; k++) if (m_cnt[k] > AEG) r = 0;
    return r;
  endfunction

  function automatic void model_step(bit v, logic [W-1:0] d, bit r);
    bit nwt [N];
    bit nrt [N];
    bit nwx [N];
    bit nrx [N];
    for (int k = 0; k < N; k++) begin
      nwt[k] = m_wt[k]; nrt[k] = m_rt[k]; nwx[k] = 0; nrx[k] = 0;
    end
    for (int k = 0; k < N; k++) begin
      if (m_wx[k]) nwt[(k + 1) % N] = 1;
      if (m_rx[k]) nrt[(k + 1) % N] = 1;
    end
    for (int k = 0; k < N; k++) begin
      bit pu = v && m_wt[k] && m_cnt[k] != D;
      bit po = r && m_rt[k] && m_cnt[k] != 0;
      if (pu) begin
        m_mem[k][m_wp[k]] = d;
        if (m_wp[k] == D - 1) begin m_wp[k] = 0; nwt[k] = 0; nwx[k] = 1; end
        else m_wp[k]++;
      end
      if (po) begin
        if (m_rp[k] == D - 1) begin m_rp[k] = 0; nrt[k] = 0; nrx[k] = 1; end
        else m_rp[k]++;
      end
      m_cnt[k] += int'(pu) - int'(po);
    end
    for (int k = 0; k < N; k++) begin
      m_wt[k] = nwt[k]; m_rt[k] = nrt[k]; m_wx[k] = nwx[k]; m_rx[k] = nrx[k];
    end
  endfunction

  task automatic cycle(bit v, logic [W-1:0] d, bit r);
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = r;
    #1;
    check("R3,R5,R6,R10,R12", "in_ready", int'(in_ready), int'(exp_ready()));
    check("R6", "wr_full", int'(wr_full), int'(exp_full()));
    check("R4,R7,R12", "out_valid", int'(out_valid), int'(exp_valid()));
    check("R7", "rd_empty", int'(rd_empty), int'(!exp_valid()));
    check("R2,R11", "out_data", int'(out_data), exp_data());
    check("R8", "near_full", int'(near_full), int'(exp_nf()));
    check("R9", "near_empty", int'(near_empty), int'(exp_ne()));
    if (r && exp_valid()) begin
      if (sb.size() == 0) begin
        check("R2", "scoreboard depth", 0, 1);
      end else begin
        check("R2", "order", int'(out_data), int'(sb.pop_front()));
      end
    end
    if (v && exp_ready()) sb.push_back(d);
    model_step(v, d, r);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] seq;
    int pv, pr;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1", "in_ready", int'(in_ready), 1);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "rd_empty", int'(rd_empty), 1);
    check("R1", "wr_full", int'(wr_full), 0);
    check("R1", "near_empty", int'(near_empty), 1);
    check("R1", "near_full", int'(near_full), 0);
    seq = 8'd1;

    // R3, R6: fill every slice, then offer extra words that must be dropped
    for (int i = 0; i < N * D + N + 4; i++) begin
      cycle(1'b1, seq, 1'b0);
      seq = seq + 1'b1;
    end
    check("R6", "full after fill", int'(wr_full), 1);

    // R4, R7: drain everything, then keep pulling on an empty queue
    for (int i = 0; i < N * D + N + 4; i++) cycle(1'b0, 8'hAA, 1'b1);
    check("R7", "empty after drain", int'(rd_empty), 1);

    // R12: both streams busy so the handoffs overlap
    for (int i = 0; i < 2; i++) begin
      cycle(1'b1, seq, 1'b0);
      seq = seq + 1'b1;
    end
    for (int i = 0; i < 120; i++) begin
      cycle(1'b1, seq, 1'b1);
      seq = seq + 1'b1;
    end

    // random traffic with shifting pressure
    for (int blk = 0; blk < 30; blk++) begin
      pv = $urandom_range(90, 10);
      pr = $urandom_range(90, 10);
      for (int i = 0; i < 60; i++) begin
        bit v = ($urandom_range(99) < pv);
        bit r = ($urandom_range(99) < pr);
        cycle(v, seq, r);
        if (v) seq = seq + 1'b1;
      end
    end

    // final drain
    for (int i = 0; i < N * D + N + 4; i++) cycle(1'b0, 8'h55, 1'b1);
    check("R2", "scoreboard empty at end", sb.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule